// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table stored in memory. A requester hands over one virtual address at a time through a valid/ready handshake. The walker splits the 20-bit virtual page number into two 10-bit indices: the upper ten bits and the lower ten bits. It then reads two table entries in turn through a synchronous memory read port that has one cycle of latency.

The first read uses the upper index. It selects an entry in the top-level table, and that entry names the base of a second-level table. The second read uses the lower index inside that second-level table and yields the frame number. The 12-bit page offset is passed through unchanged. If either entry is marked not present, the walk stops and the walker reports a fault. The fault report carries the level that failed and the virtual page number.

The start of the top-level table comes from a base register, which is written through a configuration strobe. Each table entry is 32 bits wide. Bits [31:12] hold a frame number or a table base, and bit 0 is the present flag.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready_o` is 1 and both `mem_re_o` and `rsp_valid_o` are 0.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from the next cycle through the response cycle, and it returns to 1 in the cycle after the response. While `req_ready_o` is 0, requests and address changes have no effect on the walk in progress.
- R3: In the cycle after a request is taken, `mem_re_o` is 1 and `mem_addr_o` equals the table base plus four times virtual address bits [31:22].
- R4: A cycle with `base_we_i` at 1 loads `base_i` into the table base. All later walks use the new base.
- R5: If the top-level entry has bit 0 clear, no second read is issued. `rsp_valid_o` is 1 in the third cycle after the request was taken, with `rsp_fault_o` at 1 and `rsp_lvl_o` at 0.
- R6: If the top-level entry has bit 0 set, then in the third cycle after the request was taken `mem_re_o` is 1. In that cycle `mem_addr_o` equals the entry bits [31:12] followed by twelve zero bits, plus four times virtual address bits [21:12].
- R7: If the second-level entry has bit 0 clear, `rsp_valid_o` is 1 in the fifth cycle after the request was taken, with `rsp_fault_o` at 1 and `rsp_lvl_o` at 1.
- R8: If the second-level entry has bit 0 set, `rsp_valid_o` is 1 in the fifth cycle after the request was taken. In that cycle `rsp_fault_o` is 0 and `rsp_paddr_o` equals the entry bits [31:12] followed by virtual address bits [11:0].
- R9: `rsp_valid_o` stays high for exactly one cycle per request. In that cycle `rsp_vpn_o` equals virtual address bits [31:12] of that request.
- R10: `mem_re_o` is never high in two cycles in a row, and it is high only in the read cycles that R3 and R6 name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Load strobe for the table base |
| base_i | input | 32 | New table base value |
| req_valid_i | input | 1 | A translation request is present |
| req_ready_o | output | 1 | The walker is idle and can take a request |
| req_vaddr_i | input | 32 | Virtual address to translate |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rdata_i | input | 32 | Entry data, valid one cycle after the strobe |
| rsp_valid_o | output | 1 | Response is present (single-cycle pulse) |
| rsp_fault_o | output | 1 | The walk found an entry that is not present |
| rsp_lvl_o | output | 1 | Level that faulted: 0 top level, 1 second level |
| rsp_paddr_o | output | 32 | Translated physical address |
| rsp_vpn_o | output | 20 | Virtual page number of the request |

## Verification
Let the edge that takes a request be edge zero. The first read strobe is due in cycle 1. If the walk stops at the top level, the response is due in cycle 3. Otherwise the second read is due in cycle 3 and the response in cycle 5. Ready returns one cycle after the response. The bench reference model queues one expected record per cycle when it decides a request is taken. It takes the values from its own copy of the table contents and base. At every falling edge it compares all outputs against the head of that queue, or against the idle pattern when the queue is empty. This catches a result that comes one cycle early or one cycle late.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;

  typedef enum logic {
    LVL_OUTER = 1'b0,
    LVL_INNER = 1'b1
  } walk_lvl_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int OUTER_W   = 10,
  parameter int INNER_W   = 10,
  parameter int ENTRY_SH  = 2
) (
  input  logic [PA_W-1:0]       tbl_base_i,
  input  logic [VA_W-1:0]       vaddr_i,
  input  logic [PA_W-OFF_W-1:0] inner_frame_i,
  output logic [PA_W-1:0]       outer_addr_o,
  output logic [PA_W-1:0]       inner_addr_o,
  output logic [OFF_W-1:0]      offset_o,
  output logic [VA_W-OFF_W-1:0] vpn_o
);
  logic [OUTER_W-1:0] outer_idx;
  logic [INNER_W-1:0] inner_idx;

  assign outer_idx = vaddr_i[VA_W-1 -: OUTER_W];
  assign inner_idx = vaddr_i[OFF_W +: INNER_W];
  assign offset_o  = vaddr_i[OFF_W-1:0];
  assign vpn_o     = vaddr_i[VA_W-1:OFF_W];

  assign outer_addr_o = tbl_base_i + (PA_W'(outer_idx) << ENTRY_SH);
  assign inner_addr_o = {inner_frame_i, OFF_W'(0)} + (PA_W'(inner_idx) << ENTRY_SH);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic entry_ok_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic mem_re_o,
  output logic sel_inner_o,
  output logic next_load_o,
  output logic rsp_load_o,
  output logic rsp_fault_o,
  output logic rsp_lvl_o,
  output logic rsp_valid_o
);
  walk_st_e state_q, state_d;
  logic     pend_q;
  logic     reading, evaluate;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign reading     = (state_q == ST_OUTER) || (state_q == ST_INNER);
  // first cycle of a read state issues, second consumes returned entry
  assign mem_re_o    = reading && !pend_q;
  assign evaluate    = reading && pend_q;
  assign sel_inner_o = (state_q == ST_INNER);
  assign next_load_o = evaluate && (state_q == ST_OUTER) && entry_ok_i;
  assign rsp_load_o  = evaluate && ((state_q == ST_INNER) || !entry_ok_i);
  assign rsp_fault_o = !entry_ok_i;
  assign rsp_lvl_o   = (state_q == ST_INNER) ? LVL_INNER : LVL_OUTER;
  assign rsp_valid_o = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_OUTER;
      ST_OUTER: if (evaluate) state_d = entry_ok_i ? ST_INNER : ST_DONE;
      ST_INNER: if (evaluate) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= (state_d == state_q) && reading;
    end
  end
endmodule

// File: rtl/ptw_rsp_reg.sv
module ptw_rsp_reg #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int VPN_W = 20
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic                  fault_i,
  input  logic                  lvl_i,
  input  logic [PA_W-OFF_W-1:0] frame_i,
  input  logic [OFF_W-1:0]      offset_i,
  input  logic [VPN_W-1:0]      vpn_i,
  output logic                  fault_o,
  output logic                  lvl_o,
  output logic [PA_W-1:0]       paddr_o,
  output logic [VPN_W-1:0]      vpn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      lvl_o   <= 1'b0;
      paddr_o <= '0;
      vpn_o   <= '0;
    end else if (load_i) begin
      fault_o <= fault_i;
      lvl_o   <= lvl_i;
      paddr_o <= {frame_i, offset_i};
      vpn_o   <= vpn_i;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int OUTER_W   = 10,
  parameter int INNER_W   = 10,
  parameter int ENTRY_SH  = 2,
  parameter int VALID_BIT = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  base_we_i,
  input  logic [PA_W-1:0]       base_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [VA_W-1:0]       req_vaddr_i,
  output logic                  mem_re_o,
  output logic [PA_W-1:0]       mem_addr_o,
  input  logic [PA_W-1:0]       mem_rdata_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_fault_o,
  output logic                  rsp_lvl_o,
  output logic [PA_W-1:0]       rsp_paddr_o,
  output logic [VA_W-OFF_W-1:0] rsp_vpn_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int FRM_W = PA_W - OFF_W;

  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [FRM_W-1:0] next_frame_q;
  logic [FRM_W-1:0] entry_frame;
  logic             entry_ok;
  logic             accept, sel_inner, next_load, rsp_load, fault_d, lvl_d;
  logic [PA_W-1:0]  outer_addr, inner_addr;
  logic [OFF_W-1:0] offset;
  logic [VPN_W-1:0] vpn;
  logic             unused_rdata;

  assign entry_frame  = mem_rdata_i[PA_W-1:OFF_W];
  assign entry_ok     = mem_rdata_i[VALID_BIT];
  assign unused_rdata = ^mem_rdata_i[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q       <= '0;
      vaddr_q      <= '0;
      next_frame_q <= '0;
    end else begin
      if (base_we_i) base_q <= base_i;
      if (accept)    vaddr_q <= req_vaddr_i;
      if (next_load) next_frame_q <= entry_frame;
    end
  end

  ptw_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W),
    .OUTER_W(OUTER_W), .INNER_W(INNER_W), .ENTRY_SH(ENTRY_SH)
  ) i_addr_gen (
    .tbl_base_i   (base_q),
    .vaddr_i      (vaddr_q),
    .inner_frame_i(next_frame_q),
    .outer_addr_o (outer_addr),
    .inner_addr_o (inner_addr),
    .offset_o     (offset),
    .vpn_o        (vpn)
  );

  ptw_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .entry_ok_i  (entry_ok),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .mem_re_o    (mem_re_o),
    .sel_inner_o (sel_inner),
    .next_load_o (next_load),
    .rsp_load_o  (rsp_load),
    .rsp_fault_o (fault_d),
    .rsp_lvl_o   (lvl_d),
    .rsp_valid_o (rsp_valid_o)
  );

  assign mem_addr_o = sel_inner ? inner_addr : outer_addr;

  ptw_rsp_reg #(.PA_W(PA_W), .OFF_W(OFF_W), .VPN_W(VPN_W)) i_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (rsp_load),
    .fault_i (fault_d),
    .lvl_i   (lvl_d),
    .frame_i (entry_frame),
    .offset_i(offset),
    .vpn_i   (vpn),
    .fault_o (rsp_fault_o),
    .lvl_o   (rsp_lvl_o),
    .paddr_o (rsp_paddr_o),
    .vpn_o   (rsp_vpn_o)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_ready_o,
  input logic [VA_W-1:0]       req_vaddr_i,
  input logic                  mem_re_o,
  input logic                  rsp_valid_o,
  input logic                  rsp_fault_o,
  input logic [PA_W-1:0]       rsp_paddr_o,
  input logic [VA_W-OFF_W-1:0] rsp_vpn_o
);
  logic [VA_W-1:0] cap_va;
  logic            took;
  logic            unused_chk;

  assign took       = req_valid_i && req_ready_o;
  assign unused_chk = ^rsp_paddr_o[PA_W-1:OFF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_va <= '0;
    else if (took) cap_va <= req_vaddr_i;
  end

  // R2
  busy_at_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  // R2
  ready_after_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);
  // R2
  busy_after_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took |=> !req_ready_o);
  // R3
  outer_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    took |=> mem_re_o);
  // R10
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);
  // R10
  no_read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> !req_ready_o);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  rsp_vpn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_vpn_o == cap_va[VA_W-1:OFF_W]);
  // R8
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> rsp_paddr_o[OFF_W-1:0] == cap_va[OFF_W-1:0]);
endmodule

bind pt_walker pt_walker_chk i_pt_walker_chk (.*);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        base_we_i = 1'b0;
  logic [31:0] base_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        mem_re_o;
  logic [31:0] mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        rsp_valid_o, rsp_fault_o, rsp_lvl_o;
  logic [31:0] rsp_paddr_o;
  logic [19:0] rsp_vpn_o;

  always #4 clk_i = ~clk_i;

  pt_walker i_pt_walker (.*);

  typedef struct {
    bit          re;
    bit          inner;
    logic [31:0] addr;
    bit          rsp;
    bit          fault;
    bit          lvl;
    logic [31:0] paddr;
    logic [19:0] vpn;
  } exp_t;

  logic [31:0] mem [int];
  exp_t        exp_q [$];
  logic [31:0] model_base = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          cur_ready = 1'b1;
  bit          took = 1'b0;
  bit          done = 1'b0;

  function automatic logic [31:0] mrd(input logic [31:0] a);
    int k = int'(a >> 2);
    if (mem.exists(k)) return mem[k];
    return 32'h0;
  endfunction

  task automatic mset(input logic [31:0] a, input logic [31:0] v);
    mem[int'(a >> 2)] = v;
  endtask

  always @(posedge clk_i) if (mem_re_o) mem_rdata_i <= mrd(mem_addr_o);

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic exp_t blank();
    exp_t e;
    e.re = 0; e.inner = 0; e.addr = '0; e.rsp = 0; e.fault = 0;
    e.lvl = 0; e.paddr = '0; e.vpn = '0;
    return e;
  endfunction

  task automatic push_walk(input logic [31:0] va);
    exp_t e;
    logic [31:0] oa, oe, ia, ie;
    oa = model_base + {20'h0, va[31:22], 2'b00};
    oe = mrd(oa);
    e = blank(); e.re = 1; e.addr = oa; exp_q.push_back(e);
    e = blank(); exp_q.push_back(e);
    if (!oe[0]) begin
      e = blank(); e.rsp = 1; e.fault = 1; e.lvl = 0; e.vpn = va[31:12];
      exp_q.push_back(e);
    end else begin
      ia = {oe[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      ie = mrd(ia);
      e = blank(); e.re = 1; e.inner = 1; e.addr = ia; exp_q.push_back(e);
      e = blank(); exp_q.push_back(e);
      e = blank(); e.rsp = 1; e.fault = !ie[0]; e.lvl = 1;
      e.paddr = {ie[31:12], va[11:0]}; e.vpn = va[31:12];
      exp_q.push_back(e);
    end
  endtask

  task automatic check_cycle();
    exp_t e;
    bit er;
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); er = 0; end
    else begin e = blank(); er = 1; end
    chk(req_ready_o == er, "R2 ready", {31'h0, req_ready_o}, {31'h0, er});
    chk(mem_re_o == e.re, "R10 read strobe", {31'h0, mem_re_o}, {31'h0, e.re});
    if (e.re)
      chk(mem_addr_o == e.addr, e.inner ? "R6 inner entry address" : "R3 outer entry address (base R4)",
          mem_addr_o, e.addr);
    chk(rsp_valid_o == e.rsp, "R9 response pulse", {31'h0, rsp_valid_o}, {31'h0, e.rsp});
    if (e.rsp) begin
      chk(rsp_fault_o == e.fault, e.fault ? (e.lvl ? "R7 fault" : "R5 fault") : "R8 no fault",
          {31'h0, rsp_fault_o}, {31'h0, e.fault});
      if (e.fault)
        chk(rsp_lvl_o == e.lvl, e.lvl ? "R7 level" : "R5 level", {31'h0, rsp_lvl_o}, {31'h0, e.lvl});
      else
        chk(rsp_paddr_o == e.paddr, "R8 physical address", rsp_paddr_o, e.paddr);
      chk(rsp_vpn_o == e.vpn, "R9 page number", {12'h0, rsp_vpn_o}, {12'h0, e.vpn});
    end
    cur_ready = er;
  endtask

  task automatic cycle(input bit v, input logic [31:0] va, input bit we, input logic [31:0] b);
    @(negedge clk_i);
    check_cycle();
    req_valid_i = v; req_vaddr_i = va; base_we_i = we; base_i = b;
    took = 0;
    if (we) model_base = b;
    if (v && cur_ready) begin push_walk(va); took = 1; end
  endtask

  task automatic send(input logic [31:0] va);
    do cycle(1'b1, va, 1'b0, 32'h0); while (!took);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) cycle(1'b0, 32'h0, 1'b0, 32'h0);
    cycle(1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic set_base(input logic [31:0] b);
    cycle(1'b0, 32'h0, 1'b1, b);
    cycle(1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(req_ready_o == 1'b1, "R1 ready in reset", {31'h0, req_ready_o}, 32'h1);
    chk(mem_re_o == 1'b0, "R1 read strobe in reset", {31'h0, mem_re_o}, 32'h0);
    chk(rsp_valid_o == 1'b0, "R1 response in reset", {31'h0, rsp_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1 && mem_re_o == 1'b0 && rsp_valid_o == 1'b0, "R1 idle after reset",
        {29'h0, req_ready_o, mem_re_o, rsp_valid_o}, 32'h4);

    mset(32'h0001_0004, 32'h0002_0001);
    mset(32'h0002_000C, 32'h0ABC_D001);
    mset(32'h0002_001C, 32'hFFFF_F0FF);
    mset(32'h0001_0FFC, 32'h0003_0001);
    mset(32'h0003_0FFC, 32'h1234_5001);
    mset(32'h0001_0010, 32'h0002_0000);

    set_base(32'h0001_0000);              // R4
    send(32'h0040_3ABC); drain();         // R8 success
    send(32'h0080_0000); drain();         // R5 empty top entry
    send(32'h0040_5123); drain();         // R7 empty second-level entry
    send(32'h0040_7FFF); drain();         // R8 noisy low entry bits
    send(32'hFFFF_FFFF); drain();         // R3 R6 maximum indices
    send(32'h0100_0000); drain();         // R5 frame set but not present
    send(32'h0040_3ABC); send(32'h0080_0123); drain(); // R2 held valid
    set_base(32'h0005_0000);              // R4 new base
    send(32'h0040_3ABC); drain();         // R5 under new base
    mset(32'h0005_0004, 32'h0002_0001);
    send(32'h0040_3ABC); drain();         // R8 under new base
    repeat (3) cycle(1'b0, 32'h0, 1'b0, 32'h0); // R10 idle, no reads

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule